// File: doc/BRIEF.md
# Multi-Port Memory Access Arbiter

This block sits between four requesting access points and three physical memory targets. The access points are instruction fetch, data access, register access and a DMA engine. The targets are on-chip SRAM, program flash, and the register space. Every request address is decoded by a parameterised range compare. An address inside the SRAM window goes to the SRAM, one inside the register window goes to the register space, and all other addresses go to flash.

Requests that land on different targets are all served in the same cycle. When two or more requests land on the same target, one of them is chosen by fixed priority and the others see their ready held low. A stalled requester keeps its request unchanged until ready rises. A DMA request that keeps losing is promoted after a bounded wait, so it cannot be starved.

Every target is modelled as a single-port synchronous memory. The block drives a target's enable, write enable, address and write data in the grant cycle. Read data comes back on the requesting port in the following cycle.

Top module: `mem_access_arbiter`

## Requirements
- R1: Address decode uses three target indexes: 0 = SRAM, 1 = flash, 2 = register space. Addresses 0x0000..0x1FFF (the default SRAM window) select index 0. Addresses 0x6000..0x7FFF (the default register window) select index 2. Every other address, including 0x2000, 0x5FFF, 0x8000 and 0xFFFF, selects index 1.
- R2: A target enable bit (`tgt_en[t]`) is high only when a request decoding to target t is granted. In that cycle the target's write enable, address and write data are those of the granted port.
- R3: At most one port is granted per target per cycle. A port's ready is high only while that port requests and is granted. A target with at least one request always grants one of them.
- R4: A request that meets no other request on its target sees ready high in the same cycle. For a read, the addressed byte appears on that port's read data in the next cycle.
- R5: Requests from different ports that decode to different targets are all granted in the same cycle.
- R6: When requests collide on a target, the winner follows the port order 0 (instruction fetch), 1 (data), 2 (register access), 3 (DMA). Port 0 has the highest priority.
- R7: A DMA request (port 3) that has been stalled for 4 consecutive cycles wins its target in the next cycle, ahead of every other port. Its wait counter then clears.
- R8: A stalled port keeps its request, write enable, address and write data stable until ready rises. The block then performs exactly that access, and a write becomes visible to later reads of the same address.
- R9: During and right after reset with no requests, all ready outputs and all target enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_req | input | 4 | Request per access point (bit 0 fetch, 1 data, 2 register, 3 DMA) |
| port_we | input | 4 | Write enable per access point |
| port_addr | input | 64 | Byte address per access point, 16 bits each, port p at [16p+15:16p] |
| port_wdata | input | 32 | Write data per access point, 8 bits each |
| port_ready | output | 4 | Grant/ready per access point, same cycle as the request |
| port_rdata | output | 32 | Read data per access point, valid one cycle after a read grant |
| tgt_en | output | 3 | Access strobe per target (0 SRAM, 1 flash, 2 register space) |
| tgt_we | output | 3 | Write enable per target |
| tgt_addr | output | 48 | Address per target, 16 bits each |
| tgt_wdata | output | 24 | Write data per target, 8 bits each |
| tgt_rdata | input | 24 | Registered read data from each target |

## Verification
Ready and the target-side strobes, address and write data are combinational results of the same cycle's requests. They are compared at the falling edge of the cycle in which the requests were driven. Read data passes through the target's output register and a registered return select, so it is compared at the falling edge one cycle after the grant. Writes are folded into the bench's memory image at the grant edge, so a read issued in any later cycle expects the new byte. The promotion case counts grant cycles and expects the DMA grant in the fifth cycle of its wait.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
   localparam int NUM_PORTS = 4;
   localparam int NUM_TGTS  = 3;
   localparam int TIDX_W    = 2;

   localparam int PORT_FETCH = 0;
   localparam int PORT_DATA  = 1;
   localparam int PORT_REGS  = 2;
   localparam int PORT_DMA   = 3;

   localparam logic [TIDX_W-1:0] TGT_SRAM  = 2'd0;
   localparam logic [TIDX_W-1:0] TGT_FLASH = 2'd1;
   localparam logic [TIDX_W-1:0] TGT_REGS  = 2'd2;
endpackage

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder
   import mem_arb_pkg::*;
#(
   parameter int unsigned AW      = 16,
   parameter int unsigned SRAM_LO = 32'h0000,
   parameter int unsigned SRAM_HI = 32'h1FFF,
   parameter int unsigned REG_LO  = 32'h6000,
   parameter int unsigned REG_HI  = 32'h7FFF
) (
   input  logic [AW-1:0]       addr,
   output logic [TIDX_W-1:0]   tgt_idx,
   output logic [NUM_TGTS-1:0] tgt_hot
);
   localparam logic [AW-1:0] S_LO = AW'(SRAM_LO);
   localparam logic [AW-1:0] S_HI = AW'(SRAM_HI);
   localparam logic [AW-1:0] R_LO = AW'(REG_LO);
   localparam logic [AW-1:0] R_HI = AW'(REG_HI);

   // elaboration-time parameter checks
   if (SRAM_LO > SRAM_HI) begin : g_bad_sram
      $error("SRAM window is empty");
   end
   if (REG_LO > REG_HI) begin : g_bad_reg
      $error("register window is empty");
   end
   if (!((REG_HI < SRAM_LO) || (REG_LO > SRAM_HI))) begin : g_overlap
      $error("SRAM and register windows overlap");
   end
   if ((AW < 32) && ((SRAM_HI >> AW) != 0 || (REG_HI >> AW) != 0)) begin : g_range
      $error("window limit exceeds the address width");
   end

   logic in_sram, in_regs;

   always_comb begin
      in_sram = (addr >= S_LO) && (addr <= S_HI);
      in_regs = (addr >= R_LO) && (addr <= R_HI);
      if (in_sram)      tgt_idx = TGT_SRAM;
      else if (in_regs) tgt_idx = TGT_REGS;
      else              tgt_idx = TGT_FLASH;
      tgt_hot          = '0;
      tgt_hot[tgt_idx] = 1'b1;
   end
endmodule

// File: rtl/mem_target_arbiter.sv
module mem_target_arbiter #(
   parameter int NP      = 4,
   parameter int DMA_IDX = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NP-1:0] hit,
   input  logic          promote,
   output logic [NP-1:0] grant
);
   if (DMA_IDX >= NP || DMA_IDX < 0) begin : g_bad_dma
      $error("DMA index outside the port range");
   end

   logic found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      if (promote && hit[DMA_IDX]) begin
         grant[DMA_IDX] = 1'b1;
         found          = 1'b1;
      end
      for (int i = 0; i < NP; i++) begin
         if (hit[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R3
   AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~hit) == '0); // R2
   AST_NO_IDLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |-> (grant != '0)); // R3
   AST_SOLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(hit) == 1) |-> (grant == hit)); // R4
   AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && !(promote && hit[DMA_IDX])) |-> grant[0]); // R6
endmodule

// File: rtl/mem_dma_age_tracker.sv
module mem_dma_age_tracker #(
   parameter int AGE_LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dma_req,
   input  logic dma_ready,
   output logic promote
);
   if (AGE_LIMIT < 1) begin : g_bad_limit
      $error("age limit must be at least one");
   end

   localparam int CW = $clog2(AGE_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(AGE_LIMIT);

   logic [CW-1:0] wait_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= '0;
      end else if (dma_req && !dma_ready) begin
         if (wait_cnt != LIM) wait_cnt <= wait_cnt + 1'b1;
      end else begin
         wait_cnt <= '0;
      end
   end

   assign promote = (wait_cnt == LIM);

   AST_PROMOTED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (promote && dma_req) |-> dma_ready); // R7
   AST_AGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_ready) |=> !promote); // R7
endmodule

// File: rtl/mem_access_arbiter.sv
module mem_access_arbiter
   import mem_arb_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 8,
   parameter int unsigned SRAM_LO   = 32'h0000,
   parameter int unsigned SRAM_HI   = 32'h1FFF,
   parameter int unsigned REG_LO    = 32'h6000,
   parameter int unsigned REG_HI    = 32'h7FFF,
   parameter int          AGE_LIMIT = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PORTS-1:0]      port_req,
   input  logic [NUM_PORTS-1:0]      port_we,
   input  logic [NUM_PORTS*AW-1:0]   port_addr,
   input  logic [NUM_PORTS*DW-1:0]   port_wdata,
   output logic [NUM_PORTS-1:0]      port_ready,
   output logic [NUM_PORTS*DW-1:0]   port_rdata,
   output logic [NUM_TGTS-1:0]       tgt_en,
   output logic [NUM_TGTS-1:0]       tgt_we,
   output logic [NUM_TGTS*AW-1:0]    tgt_addr,
   output logic [NUM_TGTS*DW-1:0]    tgt_wdata,
   input  logic [NUM_TGTS*DW-1:0]    tgt_rdata
);
   localparam int NP = NUM_PORTS;
   localparam int NT = NUM_TGTS;

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("address and data widths must be positive");
   end

   logic [NP-1:0][TIDX_W-1:0] dec_idx;
   logic [NP-1:0][NT-1:0]     dec_hot;
   logic [NT-1:0][NP-1:0]     hit;
   logic [NT-1:0][NP-1:0]     grant;
   logic [NP-1:0][TIDX_W-1:0] rsel_q;
   logic                      promote;

   // per-port address decode
   for (genvar p = 0; p < NP; p++) begin : g_dec
      mem_addr_decoder #(
         .AW(AW), .SRAM_LO(SRAM_LO), .SRAM_HI(SRAM_HI),
         .REG_LO(REG_LO), .REG_HI(REG_HI)
      ) u_dec (
         .addr    (port_addr[p*AW +: AW]),
         .tgt_idx (dec_idx[p]),
         .tgt_hot (dec_hot[p])
      );
      for (genvar t = 0; t < NT; t++) begin : g_hit
         assign hit[t][p] = port_req[p] && dec_hot[p][t];
      end
   end

   // DMA starvation guard, or plain fixed priority
   if (AGE_LIMIT > 0) begin : g_age
      mem_dma_age_tracker #(.AGE_LIMIT(AGE_LIMIT)) u_age (
         .clk       (clk),
         .rst_n     (rst_n),
         .dma_req   (port_req[PORT_DMA]),
         .dma_ready (port_ready[PORT_DMA]),
         .promote   (promote)
      );
   end else begin : g_no_age
      assign promote = 1'b0;
   end

   // one arbiter and one request mux per target
   for (genvar t = 0; t < NT; t++) begin : g_tgt
      mem_target_arbiter #(.NP(NP), .DMA_IDX(PORT_DMA)) u_arb (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (hit[t]),
         .promote (promote),
         .grant   (grant[t])
      );

      always_comb begin
         tgt_en[t]              = |grant[t];
         tgt_we[t]              = 1'b0;
         tgt_addr[t*AW +: AW]   = '0;
         tgt_wdata[t*DW +: DW]  = '0;
         for (int p = 0; p < NP; p++) begin
            if (grant[t][p]) begin
               tgt_we[t]             = port_we[p];
               tgt_addr[t*AW +: AW]  = port_addr[p*AW +: AW];
               tgt_wdata[t*DW +: DW] = port_wdata[p*DW +: DW];
            end
         end
      end
   end

   // ready and read return per port
   for (genvar p = 0; p < NP; p++) begin : g_port
      always_comb begin
         port_ready[p] = 1'b0;
         for (int t = 0; t < NT; t++) begin
            if (grant[t][p]) port_ready[p] = 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsel_q[p] <= TGT_SRAM;
         end else if (port_ready[p] && !port_we[p]) begin
            rsel_q[p] <= dec_idx[p];
         end
      end

      always_comb begin
         port_rdata[p*DW +: DW] = '0;
         for (int t = 0; t < NT; t++) begin
            if (rsel_q[p] == TIDX_W'(t)) port_rdata[p*DW +: DW] = tgt_rdata[t*DW +: DW];
         end
      end

      AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         port_ready[p] |-> port_req[p]); // R3
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         (port_req[p] && !port_ready[p]) |=>
            (port_req[p] && $stable(port_we[p]) && $stable(port_addr[p*AW +: AW])
             && $stable(port_wdata[p*DW +: DW]))); // R8
   end

   AST_PARALLEL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (port_req[PORT_FETCH] && port_req[PORT_DATA] && (dec_idx[PORT_FETCH] != dec_idx[PORT_DATA]))
         |-> (port_ready[PORT_FETCH] && port_ready[PORT_DATA])); // R5
endmodule

// File: tb/tb_mem_access_arbiter.sv
module tb_mem_access_arbiter;
   import mem_arb_pkg::*;

   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int NP  = NUM_PORTS;
   localparam int NT  = NUM_TGTS;
   localparam int AGE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    port_req = '0, port_we = '0;
   logic [NP*AW-1:0] port_addr = '0;
   logic [NP*DW-1:0] port_wdata = '0;
   logic [NP-1:0]    port_ready;
   logic [NP*DW-1:0] port_rdata;
   logic [NT-1:0]    tgt_en, tgt_we;
   logic [NT*AW-1:0] tgt_addr;
   logic [NT*DW-1:0] tgt_wdata;
   logic [NT*DW-1:0] tgt_rdata;

   always #5 clk = ~clk;

   mem_access_arbiter dut (
      .clk(clk), .rst_n(rst_n),
      .port_req(port_req), .port_we(port_we), .port_addr(port_addr),
      .port_wdata(port_wdata), .port_ready(port_ready), .port_rdata(port_rdata),
      .tgt_en(tgt_en), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
      .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
   );

   function automatic logic [7:0] init_val(int t, int i);
      return 8'(i * 7 + t * 85 + 3);
   endfunction

   // single-port synchronous memories, one per target
   logic [DW-1:0] ram [NT][256];
   always @(posedge clk) begin
      for (int t = 0; t < NT; t++) begin
         if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[t][i] <= init_val(t, i);
         end else if (tgt_en[t]) begin
            if (tgt_we[t]) ram[t][tgt_addr[t*AW +: 8]] <= tgt_wdata[t*DW +: DW];
            else           tgt_rdata[t*DW +: DW] <= ram[t][tgt_addr[t*AW +: 8]];
         end
      end
   end

   // bench model
   logic [7:0]  mdl [NT][256];
   logic [NP-1:0] pend = '0;
   logic        pwe  [NP];
   logic [15:0] paddr[NP];
   logic [7:0]  pwd  [NP];
   int          age = 0;
   int          cyc = 0;
   int          n_vec = 0, n_bad = 0;
   bit          done = 0;
   string       cur_rq = "R9";

   typedef struct {
      int          kind;
      int          idx;
      logic [31:0] exp;
      int          due;
      string       rq;
   } item_t;
   item_t sb[$];
   item_t keep[$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int exp_tgt(logic [15:0] a);
      if (a <= 16'h1FFF) return 0;
      if (a >= 16'h6000 && a <= 16'h7FFF) return 2;
      return 1;
   endfunction

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
      end
   endtask

   task automatic push(int kind, int idx, logic [31:0] exp, int due, string rq);
      item_t it;
      it.kind = kind; it.idx = idx; it.exp = exp; it.due = due; it.rq = rq;
      sb.push_back(it);
   endtask

   // monitor: compare every item due in this cycle
   always @(negedge clk) begin
      keep = {};
      foreach (sb[i]) begin
         if (sb[i].due == cyc) begin
            case (sb[i].kind)
               0: chk(sb[i].rq, "port_ready", 32'(port_ready), sb[i].exp);
               1: chk(sb[i].rq, "tgt_en", 32'(tgt_en), sb[i].exp);
               2: chk(sb[i].rq, $sformatf("rdata port %0d", sb[i].idx),
                      32'(port_rdata[sb[i].idx*DW +: DW]), sb[i].exp);
               3: chk(sb[i].rq, $sformatf("tgt_addr %0d", sb[i].idx),
                      32'(tgt_addr[sb[i].idx*AW +: AW]), sb[i].exp);
               4: chk(sb[i].rq, $sformatf("tgt_we %0d", sb[i].idx),
                      32'(tgt_we[sb[i].idx]), sb[i].exp);
               default: chk(sb[i].rq, $sformatf("tgt_wdata %0d", sb[i].idx),
                      32'(tgt_wdata[sb[i].idx*DW +: DW]), sb[i].exp);
            endcase
         end else begin
            keep.push_back(sb[i]);
         end
      end
      sb = keep;
   end

   task automatic issue(int p, logic we, logic [15:0] a, logic [7:0] d);
      pend[p] = 1'b1; pwe[p] = we; paddr[p] = a; pwd[p] = d;
   endtask

   // driver: one cycle of pending requests, expectations pushed
   task automatic step();
      logic [NP-1:0] rdy;
      logic [NT-1:0] en;
      int win[NT];
      @(posedge clk); #1;
      for (int p = 0; p < NP; p++) begin
         port_req[p] = pend[p];
         port_we[p]  = pend[p] ? pwe[p] : 1'b0;
         port_addr[p*AW +: AW]  = paddr[p];
         port_wdata[p*DW +: DW] = pwd[p];
      end
      rdy = '0; en = '0;
      for (int t = 0; t < NT; t++) begin
         win[t] = -1;
         if (age == AGE && pend[3] && exp_tgt(paddr[3]) == t) win[t] = 3;
         for (int p = 0; p < NP; p++)
            if (win[t] < 0 && pend[p] && exp_tgt(paddr[p]) == t) win[t] = p;
         if (win[t] >= 0) begin
            rdy[win[t]] = 1'b1;
            en[t] = 1'b1;
            push(3, t, 32'(paddr[win[t]]), cyc, "R2");
            push(4, t, 32'(pwe[win[t]]), cyc, "R2");
            if (pwe[win[t]]) push(5, t, 32'(pwd[win[t]]), cyc, "R2");
            else push(2, win[t], 32'(mdl[t][paddr[win[t]][7:0]]), cyc + 1, "R4");
         end
      end
      push(0, 0, 32'(rdy), cyc, cur_rq);
      push(1, 0, 32'(en), cyc, (cur_rq == "R1") ? "R1" : "R3");
      if (pend[3] && !rdy[3]) age = (age < AGE) ? age + 1 : age;
      else age = 0;
      for (int t = 0; t < NT; t++)
         if (win[t] >= 0 && pwe[win[t]]) mdl[t][paddr[win[t]][7:0]] = pwd[win[t]];
      pend = pend & ~rdy;
   endtask

   task automatic drain();
      while (pend != '0) step();
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] bnd [8];
      int n;
      for (int t = 0; t < NT; t++)
         for (int i = 0; i < 256; i++) mdl[t][i] = init_val(t, i);

      // R9: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "port_ready in reset", 32'(port_ready), 0);
      chk("R9", "tgt_en in reset", 32'(tgt_en), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "port_ready after reset", 32'(port_ready), 0);
      chk("R9", "tgt_en after reset", 32'(tgt_en), 0);

      // R1 / R4: window boundaries, one lone read each
      cur_rq = "R1";
      bnd = '{16'h0000, 16'h1FFF, 16'h2000, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'hFFFF};
      for (int i = 0; i < 8; i++) begin
         issue(i % NP, 1'b0, bnd[i], 8'h00);
         drain();
      end

      // R4: lone reads on every port, back to back
      cur_rq = "R4";
      issue(2, 1'b0, 16'h0033, 8'h00); step();
      issue(3, 1'b0, 16'h9044, 8'h00); step();
      issue(0, 1'b0, 16'h6012, 8'h00); step();

      // R5: three ports on three different targets at once
      cur_rq = "R5";
      issue(0, 1'b0, 16'h9000, 8'h00);
      issue(1, 1'b0, 16'h0010, 8'h00);
      issue(2, 1'b0, 16'h6010, 8'h00);
      drain();
      issue(1, 1'b0, 16'hA0A0, 8'h00);
      issue(3, 1'b0, 16'h7001, 8'h00);
      drain();

      // R6: all four ports collide on SRAM
      cur_rq = "R6";
      for (int p = 0; p < NP; p++) issue(p, 1'b0, 16'(16'h0050 + p), 8'h00);
      drain();
      issue(2, 1'b0, 16'h6100, 8'h00);
      issue(3, 1'b0, 16'h6101, 8'h00);
      issue(1, 1'b0, 16'h6102, 8'h00);
      drain();

      // R8: colliding writes, held while stalled, then read back
      cur_rq = "R8";
      issue(1, 1'b1, 16'h0020, 8'h3C);
      issue(3, 1'b1, 16'h0020, 8'hA5);
      issue(2, 1'b1, 16'h6020, 8'h77);
      drain();
      issue(0, 1'b0, 16'h0020, 8'h00);
      issue(1, 1'b0, 16'h6020, 8'h00);
      drain();
      issue(0, 1'b1, 16'hC0C0, 8'h5E);
      issue(3, 1'b0, 16'hC0C0, 8'h00);
      drain();

      // R7: DMA starved by a stream of fetch/data requests on SRAM
      cur_rq = "R7";
      issue(3, 1'b0, 16'h0100, 8'h00);
      n = 0;
      while (pend[3] && n < 20) begin
         if (!pend[0]) issue(0, 1'b0, 16'h0040, 8'h00);
         if (!pend[1]) issue(1, 1'b0, 16'h0041, 8'h00);
         step();
         n++;
      end
      chk("R7", "cycles until DMA grant", 32'(n), 32'(AGE + 1));
      drain();

      @(posedge clk); #1;
      port_req = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R3", "ready with no requests", 32'(port_ready), 0);
      done = 1;
      summary();
      $finish;
   end
endmodule